// File: doc/BRIEF.md
# PCI Memory Window Base Register and Address Decoder

This block holds the base address of one PCI memory target window and decides, for every incoming PCI memory address, whether the window claims it and where the access goes. The base is 64 KB aligned. Two agents can program it: a PCI configuration write and a write from the local processor bus. A gate input from an image control register, which lives outside this block, enables or blocks those writes. The block also drives a read view of the register for each side. The processor-bus view carries the same word with its bit order reversed.

The window size comes from a size-code input. The code is the base-2 logarithm of the window size in bytes, and it is clamped so that the window is never smaller than 64 KB. An address hits when its bits above the window size match the programmed base. The window claims nothing until the register has taken at least one accepted write. A zero base turns the window off, unless a separate override input allows it. A hit whose offset inside the window falls in the low 4 KB goes to the internal message-queue region. Every other hit is forwarded to the processor bus. The hit and route outputs are registered.

Top module: `pci_win_bar`

## Requirements
- R1: After reset the base field is zero, the window has not been written, and the prefetchable flag is 1. If `pf_ovr` is high during reset, the flag takes the value of `pf_ovr_val` instead.
- R2: The PCI read view `cfg_rdata` puts the base field in bits 31:16 and the prefetchable flag in bit 3. Bits 15:4 read as zero. Bits 2:1 (address type) read 00 and bit 0 (space, 0 = memory) reads 0.
- R3: The processor-bus read view `lb_rdata` is `cfg_rdata` with the bit order reversed: `lb_rdata[i]` equals `cfg_rdata[31-i]`. Writes on `lb_wdata` use the same reversed order.
- R4: When `bar_wr_en` is 0, writes from either side are ignored. The base and the flag keep their values, and the written-once state does not change.
- R5: The prefetchable flag can be written only from the processor-bus side. A configuration write leaves it unchanged. Bits 15:0 of a configuration write are discarded.
- R6: The window claims no address (`hit` stays 0) until at least one write has been accepted since reset.
- R7: After a write has been accepted, a base field of zero disables the window unless `zero_base_ok` is 1.
- R8: The window size is 2^`size_sel` bytes, with `size_sel` clamped to the range 16 to 31. An address hits when its bits from the size upward equal the same bits of the base.
- R9: A hit whose offset inside the window is below 4 KB drives `route_fwd` = 0 (queue region). A hit at offset 4 KB or above drives `route_fwd` = 1 (forward to the processor bus).
- R10: `hit` and `route_fwd` change on the clock edge after `mem_vld` and `mem_addr` are presented. When `mem_vld` is 0, both outputs are 0 after the next edge. `route_fwd` is 0 whenever `hit` is 0.
- R11: When both sides write in the same cycle with writes enabled, the processor-bus value wins for the base field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_ovr | input | 1 | Reset-time override of the prefetchable flag's reset value |
| pf_ovr_val | input | 1 | Value loaded into the prefetchable flag when `pf_ovr` is high |
| bar_wr_en | input | 1 | Write gate from the image control register |
| zero_base_ok | input | 1 | Allows a zero base to be a valid window |
| size_sel | input | 5 | Window size as log2 of bytes |
| cfg_wr | input | 1 | PCI configuration write strobe |
| cfg_wdata | input | 32 | PCI configuration write data |
| lb_wr | input | 1 | Processor-bus write strobe |
| lb_wdata | input | 32 | Processor-bus write data, bit order reversed |
| cfg_rdata | output | 32 | PCI read view |
| lb_rdata | output | 32 | Processor-bus read view, bit order reversed |
| mem_vld | input | 1 | A PCI memory address is presented |
| mem_addr | input | 32 | PCI memory address |
| hit | output | 1 | Registered window hit |
| route_fwd | output | 1 | Registered route: 0 = queue region, 1 = forward |

## Verification
The bench builds the block with its default parameters. The minimum window is 2^16 bytes, the queue region is 2^12 bytes, and the size code is 5 bits wide. With these values, a size code of 4 is clamped up to 64 KB, and a 1 MB window compares fewer base bits than it stores. A code of 31 exercises the largest window the clamp allows. With the small minimum window, the boundary between the queue region and the forwarded region (offsets 0x0FFF and 0x1000) can be reached directly. A zero base can be tested both with and without the override.

// File: rtl/pci_win_bar_pkg.sv
package pci_win_bar_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CODE_W = 5;

  // clamp a size code into [min_l2, WORD_W-1]
  function automatic logic [5:0] win_log2(input logic [CODE_W-1:0] code,
                                          input int unsigned min_l2);
    logic [5:0] v;
    v = {1'b0, code};
    if (v < 6'(min_l2)) v = 6'(min_l2);
    if (v > 6'(WORD_W - 1)) v = 6'(WORD_W - 1);
    return v;
  endfunction

  // ones on the address bits that are compared against the base
  function automatic logic [WORD_W-1:0] upper_mask(input logic [5:0] l2);
    return {WORD_W{1'b1}} << l2;
  endfunction

  function automatic logic [WORD_W-1:0] flip_bits(input logic [WORD_W-1:0] x);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = x[WORD_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/pci_win_bar_regs.sv
module pci_win_bar_regs
  import pci_win_bar_pkg::*;
#(
  parameter int unsigned BASE_LSB = 16,
  parameter int unsigned PF_BIT   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pf_ovr,
  input  logic                       pf_ovr_val,
  input  logic                       bar_wr_en,
  input  logic                       cfg_wr,
  input  logic [WORD_W-1:0]          cfg_wdata,
  input  logic                       lb_wr,
  input  logic [WORD_W-1:0]          lb_wdata,
  output logic [WORD_W-BASE_LSB-1:0] base_o,
  output logic                       written_o,
  output logic [WORD_W-1:0]          cfg_rdata,
  output logic [WORD_W-1:0]          lb_rdata
);
  localparam int unsigned BASE_W = WORD_W - BASE_LSB;

  logic [BASE_W-1:0] base_q;
  logic              pf_q;
  logic              written_q;
  logic [WORD_W-1:0] lb_as_pci;
  logic              cfg_take, lb_take;

  assign lb_as_pci = flip_bits(lb_wdata);
  assign cfg_take  = cfg_wr & bar_wr_en;
  assign lb_take   = lb_wr & bar_wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= '0;
      pf_q      <= pf_ovr ? pf_ovr_val : 1'b1;
      written_q <= 1'b0;
    end else begin
      if (lb_take)       base_q <= lb_as_pci[WORD_W-1:BASE_LSB];
      else if (cfg_take) base_q <= cfg_wdata[WORD_W-1:BASE_LSB];
      if (lb_take)       pf_q   <= lb_as_pci[PF_BIT];
      if (cfg_take || lb_take) written_q <= 1'b1;
    end
  end

  always_comb begin
    cfg_rdata                      = '0;
    cfg_rdata[WORD_W-1:BASE_LSB]   = base_q;
    cfg_rdata[PF_BIT]              = pf_q;
  end
  assign lb_rdata  = flip_bits(cfg_rdata);
  assign base_o    = base_q;
  assign written_o = written_q;

  // R4
  gated_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bar_wr_en |=> $stable(base_q) && $stable(pf_q) && $stable(written_q));
  // R5
  pf_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lb_wr && bar_wr_en) |=> $stable(pf_q));
  // R6
  written_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    written_q |=> written_q);
endmodule

// File: rtl/pci_win_bar_decode.sv
module pci_win_bar_decode
  import pci_win_bar_pkg::*;
#(
  parameter int unsigned BASE_LSB  = 16,
  parameter int unsigned LOCAL_L2  = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WORD_W-BASE_LSB-1:0] base,
  input  logic                       written,
  input  logic                       zero_base_ok,
  input  logic [CODE_W-1:0]          size_sel,
  input  logic                       mem_vld,
  input  logic [WORD_W-1:0]          mem_addr,
  output logic                       hit,
  output logic                       route_fwd
);
  logic [5:0]        l2;
  logic [WORD_W-1:0] msk, base_addr, offset;
  logic              dec_en, match, in_queue;
  logic              hit_q, route_q;

  assign l2        = win_log2(size_sel, BASE_LSB);
  assign msk       = upper_mask(l2);
  assign base_addr = {base, {BASE_LSB{1'b0}}};
  assign dec_en    = written && ((base != '0) || zero_base_ok);
  assign match     = ((mem_addr ^ base_addr) & msk) == '0;
  assign offset    = mem_addr & ~msk;
  assign in_queue  = offset < (WORD_W'(1) << LOCAL_L2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      route_q <= 1'b0;
    end else begin
      hit_q   <= mem_vld && dec_en && match;
      route_q <= mem_vld && dec_en && match && !in_queue;
    end
  end
  assign hit       = hit_q;
  assign route_fwd = route_q;

  // R6
  unwritten_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !written |=> !hit_q);
  // R7
  zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base == '0 && !zero_base_ok) |=> !hit_q);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_vld |=> !hit_q && !route_q);
  // R10
  route_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_q |-> hit_q);
endmodule

// File: rtl/pci_win_bar.sv
module pci_win_bar
  import pci_win_bar_pkg::*;
#(
  parameter int unsigned BASE_LSB = 16,
  parameter int unsigned LOCAL_L2 = 12,
  parameter int unsigned PF_BIT   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pf_ovr,
  input  logic        pf_ovr_val,
  input  logic        bar_wr_en,
  input  logic        zero_base_ok,
  input  logic [4:0]  size_sel,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  input  logic        lb_wr,
  input  logic [31:0] lb_wdata,
  output logic [31:0] cfg_rdata,
  output logic [31:0] lb_rdata,
  input  logic        mem_vld,
  input  logic [31:0] mem_addr,
  output logic        hit,
  output logic        route_fwd
);
  logic [WORD_W-BASE_LSB-1:0] base_w;
  logic                       written_w;

  pci_win_bar_regs #(.BASE_LSB(BASE_LSB), .PF_BIT(PF_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .pf_ovr(pf_ovr), .pf_ovr_val(pf_ovr_val),
    .bar_wr_en(bar_wr_en), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .lb_wr(lb_wr), .lb_wdata(lb_wdata), .base_o(base_w),
    .written_o(written_w), .cfg_rdata(cfg_rdata), .lb_rdata(lb_rdata)
  );

  pci_win_bar_decode #(.BASE_LSB(BASE_LSB), .LOCAL_L2(LOCAL_L2)) u_dec (
    .clk(clk), .rst_n(rst_n), .base(base_w), .written(written_w),
    .zero_base_ok(zero_base_ok), .size_sel(size_sel), .mem_vld(mem_vld),
    .mem_addr(mem_addr), .hit(hit), .route_fwd(route_fwd)
  );
endmodule

// File: tb/pci_win_bar_tb.sv
module pci_win_bar_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst_n, pf_ovr, pf_ovr_val, bar_wr_en, zero_base_ok;
  logic [4:0] size_sel;
  logic cfg_wr, lb_wr, mem_vld;
  logic [31:0] cfg_wdata, lb_wdata, mem_addr;
  logic [31:0] cfg_rdata, lb_rdata;
  logic hit, route_fwd;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_win_bar u_dut (
    .clk(clk), .rst_n(rst_n), .pf_ovr(pf_ovr), .pf_ovr_val(pf_ovr_val),
    .bar_wr_en(bar_wr_en), .zero_base_ok(zero_base_ok), .size_sel(size_sel),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .lb_wr(lb_wr), .lb_wdata(lb_wdata),
    .cfg_rdata(cfg_rdata), .lb_rdata(lb_rdata), .mem_vld(mem_vld),
    .mem_addr(mem_addr), .hit(hit), .route_fwd(route_fwd)
  );

  // {size_sel, mem_addr, exp_hit, exp_route}; base programmed to 0x1234
  localparam int NV = 14;
  localparam logic [38:0] VEC [NV] = '{
    {5'd16, 32'h1234_0000, 1'b1, 1'b0},
    {5'd16, 32'h1234_0FFF, 1'b1, 1'b0},
    {5'd16, 32'h1234_1000, 1'b1, 1'b1},
    {5'd16, 32'h1235_0000, 1'b0, 1'b0},
    {5'd16, 32'h1233_FFFF, 1'b0, 1'b0},
    {5'd4,  32'h1235_0000, 1'b0, 1'b0},
    {5'd4,  32'h1234_FFFC, 1'b1, 1'b1},
    {5'd20, 32'h1230_0000, 1'b1, 1'b0},
    {5'd20, 32'h1234_0000, 1'b1, 1'b1},
    {5'd20, 32'h123F_F000, 1'b1, 1'b1},
    {5'd20, 32'h1240_0000, 1'b0, 1'b0},
    {5'd31, 32'h0000_0800, 1'b1, 1'b0},
    {5'd31, 32'h7FFF_0000, 1'b1, 1'b1},
    {5'd31, 32'h8000_0000, 1'b0, 1'b0}
  };

  function automatic logic [31:0] rev(input logic [31:0] x);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[31-k] = x[k];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_wr = 0; lb_wr = 0; mem_vld = 0; cfg_wdata = '0; lb_wdata = '0; mem_addr = '0;
  endtask

  task automatic do_reset(input logic ovr, input logic val);
    @(negedge clk);
    rst_n = 0; pf_ovr = ovr; pf_ovr_val = val; idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1; pf_ovr = 0;
  endtask

  task automatic wr(input logic c, input logic [31:0] cd, input logic l, input logic [31:0] ld);
    @(negedge clk);
    cfg_wr = c; cfg_wdata = cd; lb_wr = l; lb_wdata = ld;
    @(negedge clk);
    cfg_wr = 0; lb_wr = 0;
  endtask

  task automatic probe(input logic [4:0] sz, input logic [31:0] a, input logic vld,
                       input logic eh, input logic er, input string req);
    @(negedge clk);
    size_sel = sz; mem_addr = a; mem_vld = vld;
    @(negedge clk);
    chk(req, {31'b0, hit}, {31'b0, eh});
    chk(req, {31'b0, route_fwd}, {31'b0, er});
    mem_vld = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bar_wr_en = 0; zero_base_ok = 0; size_sel = 5'd16; rst_n = 0;
    pf_ovr = 0; pf_ovr_val = 0; idle_inputs();

    // R1: override at reset
    do_reset(1'b1, 1'b0);
    @(negedge clk);
    chk("R1 pf override", cfg_rdata, 32'h0000_0000);
    // R1: plain reset
    do_reset(1'b0, 1'b0);
    @(negedge clk);
    chk("R1 reset view", cfg_rdata, 32'h0000_0008);
    chk("R3 reset lb view", lb_rdata, rev(32'h0000_0008));
    // R6: not yet written, zero base allowed, still no claim
    zero_base_ok = 1;
    probe(5'd16, 32'h0000_0100, 1'b1, 1'b0, 1'b0, "R6 unwritten");
    // R4: gated writes ignored, window still unclaimed
    bar_wr_en = 0;
    wr(1'b1, 32'h5555_0000, 1'b1, rev(32'h6666_0000));
    chk("R4 gated write", cfg_rdata, 32'h0000_0008);
    probe(5'd16, 32'h0000_0100, 1'b1, 1'b0, 1'b0, "R4 gated no written");
    // R2/R5: cfg write, low bits discarded, pf kept
    bar_wr_en = 1; zero_base_ok = 0;
    wr(1'b1, 32'h1234_FFF7, 1'b0, '0);
    chk("R2 R5 cfg write", cfg_rdata, 32'h1234_0008);
    chk("R3 lb view", lb_rdata, rev(32'h1234_0008));
    // R3/R5: lb write with reversed bits clears pf
    wr(1'b0, '0, 1'b1, rev(32'hABCD_0000));
    chk("R3 R5 lb write", cfg_rdata, 32'hABCD_0000);
    // R11: simultaneous writes
    wr(1'b1, 32'h1111_0000, 1'b1, rev(32'h2222_0008));
    chk("R11 lb wins", cfg_rdata, 32'h2222_0008);
    // R7: zero base
    wr(1'b1, 32'h0000_0000, 1'b0, '0);
    probe(5'd16, 32'h0000_0100, 1'b1, 1'b0, 1'b0, "R7 zero disabled");
    zero_base_ok = 1;
    probe(5'd16, 32'h0000_0100, 1'b1, 1'b1, 1'b0, "R7 zero allowed");
    probe(5'd16, 32'h0000_2000, 1'b1, 1'b1, 1'b1, "R7 R9 zero fwd");
    zero_base_ok = 0;
    // R8/R9 table
    wr(1'b1, 32'h1234_0000, 1'b0, '0);
    for (int i = 0; i < NV; i++) begin
      probe(VEC[i][38:34], VEC[i][33:2], 1'b1, VEC[i][1], VEC[i][0], "R8 R9 vector");
    end
    // R10: valid low gives no hit on a matching address
    probe(5'd16, 32'h1234_1000, 1'b0, 1'b0, 1'b0, "R10 idle");
    // R10: one-cycle latency, output clears the cycle after valid drops
    @(negedge clk);
    size_sel = 5'd16; mem_addr = 32'h1234_2000; mem_vld = 1;
    chk("R10 before edge", {31'b0, hit}, 32'd0);
    @(negedge clk);
    mem_vld = 0;
    chk("R10 after edge", {30'b0, hit, route_fwd}, 32'd3);
    @(negedge clk);
    chk("R10 drop", {30'b0, hit, route_fwd}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule